// File: doc/BRIEF.md
# I2C Register Slave with Wrapping Pointer

This block is the serial front end of a small register-mapped peripheral. It watches oversampled SCL and SDA lines in the system clock domain and detects START, repeated START and STOP. It frames bits into bytes and answers a 7-bit device address whose lowest bit comes from a strap pin. It acknowledges each accepted byte by pulling SDA low through an open-drain output enable.

A write transfer uses its first data byte as the register pointer. Every byte after that goes out on a simple register port at the pointer, and the pointer then steps forward. A read transfer sends bytes fetched from the register port, starting at the current pointer. It keeps sending for as long as the master acknowledges. The pointer space is not a power of two: after register 10h the pointer returns to 00h. Two single-cycle strobes are provided for the neighbouring snapshot logic, which copies a running counter into shadow registers. One strobe fires on every START, including a repeated START. The other fires whenever the pointer wraps to 00h.

Top module: `i2cs_wrap_top`

## Requirements
- R1: The slave acknowledges (drives SDA low during the ninth clock) an address byte whose upper seven bits equal binary 110100 followed by the level of `addr_sel`. Bit 0 of that byte is the direction: 1 selects read and 0 selects write.
- R2: After an address byte that does not match, the slave never drives SDA and performs no register write or pointer change until the next START or STOP. Every later byte in that transfer therefore reads back as not acknowledged.
- R3: In a write transfer, the first byte after the address loads the pointer from its low address bits and causes no register write.
- R4: Each further write byte is acknowledged and produces one `reg_wr` pulse that carries the byte at the current pointer. The pointer then advances by one.
- R5: The pointer advances from 10h to 00h, in both write and read transfers. Each such wrap produces exactly one single-cycle `wrap_strobe` pulse.
- R6: In a read transfer, the slave sends the register at the pointer, most significant bit first, and advances the pointer after each byte. It sends the next register for as long as the master acknowledges.
- R7: When the master answers a read byte with NACK, the slave releases SDA and stays silent for the rest of the transfer.
- R8: The pointer is kept across STOP. A read that is not preceded by a pointer write starts where the previous transfer left the pointer.
- R9: A repeated START after a pointer write begins a new address phase without a STOP, so the pointer-write-then-read sequence works.
- R10: Every START and every repeated START produces exactly one single-cycle `start_strobe` pulse.
- R11: The slave changes `sda_oe` only while SCL is low.
- R12: After reset, `sda_oe`, `reg_wr`, `start_strobe` and `wrap_strobe` are low and the pointer is 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| addr_sel | input | 1 | Strap that supplies the lowest device address bit |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_addr | output | ADDR_W (5) | Register pointer presented to the register file |
| reg_wr | output | 1 | Single-cycle write strobe for `reg_wdata` at `reg_addr` |
| reg_wdata | output | 8 | Byte to write |
| reg_rdata | input | 8 | Register contents at `reg_addr` (combinational read) |
| start_strobe | output | 1 | Single-cycle pulse per START or repeated START |
| wrap_strobe | output | 1 | Single-cycle pulse when the pointer wraps to 00h |

## Verification
The bench writes and reads across the 10h-to-00h boundary in both directions. A design that wrapped at a power of two would land in 11h and leave register 00h unwritten. It would also raise no wrap strobe. The bench starts a read with no pointer write after a STOP, and it also sends a pointer write followed by a repeated START. These catch a pointer that is reset between transfers and a repeated START that is not recognised. It sends a non-matching address with data behind it and keeps clocking after a NACK. A slave that still acknowledged, loaded the pointer or kept driving data would show up as acknowledged bytes, moved data, or bits other than 1 on the line. The strap value is flipped to confirm that the lowest address bit follows the pin.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int BYTE_W = 8;
    localparam logic [5:0] DEV_ADDR_HI = 6'b110100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_IGNORE
    } slv_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic sel);
        return b[BYTE_W-1:1] == {DEV_ADDR_HI, sel};
    endfunction

endpackage

// File: rtl/i2cs_bus_cond.sv
module i2cs_bus_cond
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);
    // SYNC_STAGES must be at least 2.
    logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_d, sda_d;
    logic scl_s, sda_s;

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_d    <= scl_s;
            sda_d    <= sda_s;
        end
    end

    always_comb begin
        ev_o.scl      = scl_s;
        ev_o.sda      = sda_s;
        ev_o.scl_rise = scl_s & ~scl_d;
        ev_o.scl_fall = ~scl_s & scl_d;
        ev_o.start    = scl_s & scl_d & sda_d & ~sda_s;
        ev_o.stop     = scl_s & scl_d & ~sda_d & sda_s;
    end

    // R10: a START condition cannot be seen on two consecutive cycles
    a_r10_start_single: assert property (@(posedge clk) disable iff (rst)
        ev_o.start |=> !ev_o.start);

endmodule

// File: rtl/i2cs_ptr.sv
module i2cs_ptr #(
    parameter int ADDR_W   = 5,
    parameter int LAST_REG = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              inc_i,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              wrap_o
);
    localparam logic [ADDR_W-1:0] LAST_P = ADDR_W'(LAST_REG);

    logic [ADDR_W-1:0] ptr_q;
    logic              wrap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            wrap_q <= 1'b0;
        end else begin
            wrap_q <= 1'b0;
            if (load_i) begin
                ptr_q <= load_val_i;
            end else if (inc_i) begin
                if (ptr_q >= LAST_P) begin
                    ptr_q  <= '0;
                    wrap_q <= 1'b1;
                end else begin
                    ptr_q <= ptr_q + 1'b1;
                end
            end
        end
    end

    assign ptr_o  = ptr_q;
    assign wrap_o = wrap_q;

    // R5: stepping past the last register lands on 00h with a wrap pulse
    a_r5_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (ptr_q == LAST_P && inc_i && !load_i) |=> (ptr_q == '0 && wrap_o));

    // R5: the wrap pulse lasts a single cycle
    a_r5_wrap_single: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> !wrap_o);

endmodule

// File: rtl/i2cs_wrap_top.sv
module i2cs_wrap_top
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 5,
    parameter int LAST_REG    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_sel,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic [7:0]        reg_wdata,
    input  logic [7:0]        reg_rdata,
    output logic              start_strobe,
    output logic              wrap_strobe
);
    localparam logic [2:0] LAST_BIT = 3'(BYTE_W - 1);

    bus_ev_t           ev;
    slv_state_e        state;
    logic [2:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] rx_byte;
    logic              rw_q, ack_phase, first_q, more_q;
    logic              oe_q, wr_q, start_q;
    logic [BYTE_W-1:0] wdata_q;
    logic              load_q, inc_q;
    logic [ADDR_W-1:0] load_val_q;
    logic [ADDR_W-1:0] ptr;

    i2cs_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    i2cs_ptr #(.ADDR_W(ADDR_W), .LAST_REG(LAST_REG)) u_ptr (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load_q),
        .load_val_i (load_val_q),
        .inc_i      (inc_q),
        .ptr_o      (ptr),
        .wrap_o     (wrap_strobe)
    );

    assign rx_byte = {shreg[BYTE_W-2:0], ev.sda};

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            rw_q       <= 1'b0;
            ack_phase  <= 1'b0;
            first_q    <= 1'b0;
            more_q     <= 1'b0;
            oe_q       <= 1'b0;
            wr_q       <= 1'b0;
            wdata_q    <= '0;
            start_q    <= 1'b0;
            load_q     <= 1'b0;
            inc_q      <= 1'b0;
            load_val_q <= '0;
        end else begin
            wr_q    <= 1'b0;
            load_q  <= 1'b0;
            inc_q   <= 1'b0;
            start_q <= ev.start;
            if (ev.start) begin
                state     <= ST_ADDR;
                bit_cnt   <= '0;
                oe_q      <= 1'b0;
                ack_phase <= 1'b0;
            end else if (ev.stop) begin
                state <= ST_IDLE;
                oe_q  <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (ev.scl_rise) begin
                            shreg   <= rx_byte;
                            bit_cnt <= bit_cnt + 3'd1;
                            if (bit_cnt == LAST_BIT) begin
                                if (addr_hit(rx_byte, addr_sel)) begin
                                    state     <= ST_ADDR_ACK;
                                    rw_q      <= rx_byte[0];
                                    ack_phase <= 1'b0;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.scl_fall) begin
                            if (!ack_phase) begin
                                oe_q      <= 1'b1;
                                ack_phase <= 1'b1;
                            end else begin
                                ack_phase <= 1'b0;
                                bit_cnt   <= '0;
                                if (rw_q) begin
                                    state <= ST_RD;
                                    shreg <= reg_rdata;
                                    oe_q  <= ~reg_rdata[BYTE_W-1];
                                end else begin
                                    state   <= ST_WR;
                                    first_q <= 1'b1;
                                    oe_q    <= 1'b0;
                                end
                            end
                        end
                    end
                    ST_WR: begin
                        if (ev.scl_rise) begin
                            shreg   <= rx_byte;
                            bit_cnt <= bit_cnt + 3'd1;
                            if (bit_cnt == LAST_BIT) begin
                                if (first_q) begin
                                    load_q     <= 1'b1;
                                    load_val_q <= rx_byte[ADDR_W-1:0];
                                    first_q    <= 1'b0;
                                end else begin
                                    wr_q    <= 1'b1;
                                    wdata_q <= rx_byte;
                                    inc_q   <= 1'b1;
                                end
                                state     <= ST_WR_ACK;
                                ack_phase <= 1'b0;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (ev.scl_fall) begin
                            if (!ack_phase) begin
                                oe_q      <= 1'b1;
                                ack_phase <= 1'b1;
                            end else begin
                                oe_q      <= 1'b0;
                                ack_phase <= 1'b0;
                                bit_cnt   <= '0;
                                state     <= ST_WR;
                            end
                        end
                    end
                    ST_RD: begin
                        if (ev.scl_fall) begin
                            shreg <= {shreg[BYTE_W-2:0], 1'b0};
                            oe_q  <= ~shreg[BYTE_W-2];
                        end else if (ev.scl_rise) begin
                            bit_cnt <= bit_cnt + 3'd1;
                            if (bit_cnt == LAST_BIT) begin
                                state     <= ST_RD_ACK;
                                inc_q     <= 1'b1;
                                ack_phase <= 1'b0;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (ev.scl_fall) begin
                            if (!ack_phase) begin
                                oe_q      <= 1'b0;
                                ack_phase <= 1'b1;
                            end else begin
                                ack_phase <= 1'b0;
                                if (more_q) begin
                                    state   <= ST_RD;
                                    shreg   <= reg_rdata;
                                    oe_q    <= ~reg_rdata[BYTE_W-1];
                                    bit_cnt <= '0;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end
                        end else if (ev.scl_rise && ack_phase) begin
                            more_q <= ~ev.sda;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe       = oe_q;
    assign reg_addr     = ptr;
    assign reg_wr       = wr_q;
    assign reg_wdata    = wdata_q;
    assign start_strobe = start_q;

    // R11: the output enable only moves while SCL is low (bus conditions excepted)
    a_r11_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
        (!$stable(oe_q) && !$past(ev.start || ev.stop)) |-> !$past(ev.scl));

    // R2, R7: a silenced slave never pulls SDA
    a_r2_ignore_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> !oe_q);

    // R4: register writes only come out of a write transfer's data byte
    a_r4_wr_in_write: assert property (@(posedge clk) disable iff (rst)
        wr_q |-> (!rw_q && state == ST_WR_ACK));

    // R10: START strobe is one cycle wide
    a_r10_strobe_single: assert property (@(posedge clk) disable iff (rst)
        start_q |=> !start_q);

endmodule

// File: tb/i2cs_wrap_top_bench.sv
module i2cs_wrap_top_bench;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       addr_sel = 1'b0;
    logic       sda_oe, reg_wr, start_strobe, wrap_strobe;
    logic [4:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       sda_bus;
    logic [7:0] mem [0:16];

    int n_chk = 0, n_fail = 0;
    int n_start = 0, n_wrap = 0, n_wr = 0, n_oe_hi = 0, n_viol = 0;
    logic oe_prev = 1'b0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    assign sda_bus   = sda_m & ~sda_oe;
    assign reg_rdata = (reg_addr <= 5'd16) ? mem[reg_addr] : 8'h00;

    i2cs_wrap_top u_i2cs_wrap_top (
        .clk          (clk),
        .rst          (rst),
        .scl_i        (scl_m),
        .sda_i        (sda_bus),
        .addr_sel     (addr_sel),
        .sda_oe       (sda_oe),
        .reg_addr     (reg_addr),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .start_strobe (start_strobe),
        .wrap_strobe  (wrap_strobe)
    );

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i <= 16; i++) mem[i] <= 8'h40 + 8'(i);
        end else begin
            if (reg_wr && reg_addr <= 5'd16) mem[reg_addr] <= reg_wdata;
            if (start_strobe) n_start++;
            if (wrap_strobe) n_wrap++;
            if (reg_wr) n_wr++;
            if (sda_oe) n_oe_hi++;
            if (sda_oe != oe_prev && scl_m) n_viol++;
            oe_prev = sda_oe;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start;
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic m_stop;
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b1; wait_clk(Q);
    endtask

    task automatic m_bit_out(input logic b);
        sda_m = b;    wait_clk(Q);
        scl_m = 1'b1; wait_clk(2 * Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic m_bit_in(output logic b);
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        b = sda_bus;  wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic m_send(input logic [7:0] d, output logic ack);
        for (int i = 7; i >= 0; i--) m_bit_out(d[i]);
        m_bit_in(ack);
    endtask

    task automatic m_recv(input logic ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            m_bit_in(b);
            d[i] = b;
        end
        m_bit_out(ack);
    endtask

    task automatic t_reset;
        wait_clk(3);
        chk("R12 sda_oe", int'(sda_oe), 0);
        chk("R12 reg_wr", int'(reg_wr), 0);
        chk("R12 start_strobe", int'(start_strobe), 0);
        chk("R12 wrap_strobe", int'(wrap_strobe), 0);
        chk("R12 pointer", int'(reg_addr), 0);
    endtask

    task automatic t_write_burst;
        logic a;
        int w0 = n_wr;
        m_start;
        m_send(8'hD0, a); chk("R1 address ack", int'(a), 0);
        m_send(8'h03, a); chk("R3 pointer ack", int'(a), 0);
        m_send(8'hA1, a); chk("R4 data ack", int'(a), 0);
        m_send(8'hB2, a);
        m_send(8'hC3, a); chk("R4 last data ack", int'(a), 0);
        m_stop;
        chk("R3 pointer byte not written", n_wr - w0, 3);
        chk("R4 reg 3", int'(mem[3]), 'hA1);
        chk("R4 reg 4", int'(mem[4]), 'hB2);
        chk("R4 reg 5", int'(mem[5]), 'hC3);
        chk("R3 reg 2 untouched", int'(mem[2]), 'h42);
    endtask

    task automatic t_random_read;
        logic a;
        logic [7:0] d;
        int s0 = n_start;
        m_start;
        m_send(8'hD0, a);
        m_send(8'h03, a);
        m_start;
        m_send(8'hD1, a); chk("R9 read address ack after Sr", int'(a), 0);
        m_recv(1'b0, d); chk("R6 read byte 0", int'(d), 'hA1);
        m_recv(1'b0, d); chk("R6 read byte 1", int'(d), 'hB2);
        m_recv(1'b1, d); chk("R6 read byte 2", int'(d), 'hC3);
        m_stop;
        chk("R10 start strobes", n_start - s0, 2);
    endtask

    task automatic t_current_read;
        logic a;
        logic [7:0] d;
        int h0;
        m_start;
        m_send(8'hD1, a);
        m_recv(1'b1, d); chk("R8 current pointer read", int'(d), 'h46);
        h0 = n_oe_hi;
        for (int i = 7; i >= 0; i--) begin
            logic b;
            m_bit_in(b);
            d[i] = b;
        end
        chk("R7 line idle after NACK", int'(d), 'hFF);
        chk("R7 no drive after NACK", n_oe_hi - h0, 0);
        m_stop;
    endtask

    task automatic t_wrap_write;
        logic a;
        int w0 = n_wrap;
        m_start;
        m_send(8'hD0, a);
        m_send(8'h0F, a);
        m_send(8'h11, a);
        m_send(8'h22, a);
        m_send(8'h33, a); chk("R5 ack after wrap", int'(a), 0);
        m_stop;
        chk("R5 reg 0F", int'(mem[15]), 'h11);
        chk("R5 reg 10", int'(mem[16]), 'h22);
        chk("R5 reg 00 after wrap", int'(mem[0]), 'h33);
        chk("R5 wrap strobe on write", n_wrap - w0, 1);
    endtask

    task automatic t_wrap_read;
        logic a;
        logic [7:0] d;
        int w0 = n_wrap;
        m_start;
        m_send(8'hD0, a);
        m_send(8'h10, a);
        m_start;
        m_send(8'hD1, a);
        m_recv(1'b0, d); chk("R5 read reg 10", int'(d), 'h22);
        m_recv(1'b1, d); chk("R5 read wraps to 00", int'(d), 'h33);
        m_stop;
        chk("R5 wrap strobe on read", n_wrap - w0, 1);
    endtask

    task automatic t_mismatch;
        logic a;
        logic [7:0] d;
        int h0 = n_oe_hi, w0 = n_wr;
        addr_sel = 1'b0;
        m_start;
        m_send(8'hD2, a); chk("R2 no ack on mismatch", int'(a), 1);
        m_send(8'h05, a); chk("R2 no ack on later byte", int'(a), 1);
        m_send(8'hEE, a);
        m_stop;
        chk("R2 no drive", n_oe_hi - h0, 0);
        chk("R2 no write", n_wr - w0, 0);
        m_start;
        m_send(8'hD1, a);
        m_recv(1'b1, d); chk("R2 pointer untouched", int'(d), 'h41);
        m_stop;
    endtask

    task automatic t_strap;
        logic a;
        logic [7:0] d;
        addr_sel = 1'b1;
        wait_clk(Q);
        m_start;
        m_send(8'hD2, a); chk("R1 strap high ack", int'(a), 0);
        m_send(8'h02, a);
        m_send(8'h5A, a);
        m_stop;
        chk("R1 strap write", int'(mem[2]), 'h5A);
        m_start;
        m_send(8'hD3, a);
        m_recv(1'b1, d); chk("R1 strap read", int'(d), 'hA1);
        m_stop;
        m_start;
        m_send(8'hD0, a); chk("R1 old address rejected", int'(a), 1);
        m_stop;
    endtask

    initial begin
        wait_clk(5);
        rst = 1'b0;
        t_reset;
        t_write_burst;
        t_random_read;
        t_current_read;
        t_wrap_write;
        t_wrap_read;
        t_mismatch;
        t_strap;
        chk("R11 oe moved while SCL high", n_viol, 0);
        chk("R11 oe was exercised", int'(n_oe_hi > 0), 1);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule